// File: doc/BRIEF.md
# Parallel Multi-Lane LED String Transmitter

This block drives a set of serial LED strings of the single-wire, 800 kbit/s kind in lockstep, one output lane per string. A host first fills a bit-plane memory through a plain write port. Each memory word stands for one bit slot of the frame, and bit i of that word is the data bit for lane i. A pulse on the start input then sends a whole frame. All enabled lanes share one slot timebase. Every lane goes high at the start of a slot. Lanes carrying a 0 drop at one third of the slot, and every lane is low from two thirds of the slot onward.

For the host, a pixel is 24 consecutive words: the green byte, then red, then blue, each most significant bit first. The pixels of a string follow one another at ascending addresses from address 0. Two empty slots come before the data and one empty slot follows it. A busy output covers the frame and a one-cycle done pulse closes it. A guard timer then holds off the next frame for the latch gap the LEDs need. A start that arrives too early is remembered and served once that gap has passed.

Top module: `parallel_strip_tx`

## Requirements
- R1: After reset `lanes_o`, `busy_o` and `done_o` are 0, and `lanes_o` stays 0 whenever `busy_o` is low.
- R2: A bit slot lasts SLOT_CYC = 60 clocks at the default 48 MHz. Successive rising edges on a lane during the data are exactly SLOT_CYC clocks apart.
- R3: A data bit of 1 produces a high pulse of T1H = 40 clocks. A data bit of 0 produces a high pulse of T0H = 20 clocks. No other pulse width appears.
- R4: Bit i of the memory word at address w drives lane i in data slot w. Addresses 0 to 24*N-1 are sent in ascending order, where N is `led_count_i` sampled at start. The host places pixel p at words 24p to 24p+23 as green, red, blue, each MSB first.
- R5: Lanes whose bit in `lane_en_i` (sampled at start) is 0 stay low for the whole frame.
- R6: Two empty slots lead the frame. The first rising lane edge comes 2*SLOT_CYC+1 clocks after `busy_o` rises.
- R7: One empty slot trails the data. `done_o` is high for exactly one clock, `busy_o` falls in that same clock, and the pulse comes 2*SLOT_CYC-T1H-1 clocks after the last falling lane edge.
- R8: `busy_o` does not rise again until at least GUARD_CYC = 2400 clocks (50 µs) after `done_o`, even if start is requested during that gap.
- R9: A start pulse during a frame is held pending and starts the next frame after the guard gap without any further request.
- R10: With `led_count_i` = 0 a frame is three empty slots: no lane pulses, and `done_o` comes 3*SLOT_CYC clocks after `busy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (48 MHz nominal) |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame request pulse |
| led_count_i | input | 6 | LEDs per string for the frame |
| lane_en_i | input | 16 | Lane enable mask |
| wr_en_i | input | 1 | Bit-plane memory write strobe |
| wr_addr_i | input | 11 | Bit-plane word address |
| wr_data_i | input | 16 | Bit-plane word, one bit per lane |
| lanes_o | output | 16 | Serial data outputs, one per string |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench decodes every lane back into colour bytes from its pulse widths. A lane swap, a bit-order error or a fetch that arrives after the one-third point therefore shows up as wrong colours or as pulses that are neither 20 nor 40 clocks wide. It measures the gap from busy to the first edge and from the last edge to done. A design that dropped or added a padding slot would shift one of these by 60 clocks. It requests a frame during a frame and another during the guard gap. A design that dropped the pending request would never finish the second frame, and one that ignored the guard would restart too soon. A zero-length frame and a sparse enable mask catch designs that pulse on empty or disabled lanes.

// File: rtl/parallel_strip_tx_pkg.sv
package parallel_strip_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_GUARD = 2'd2
    } tx_state_e;

    localparam int BITS_PER_LED = 24;
    localparam int LEAD_SLOTS   = 2;

endpackage

// File: rtl/lane_plane_ram.sv
module lane_plane_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1440,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
        if (rd_en_i) begin
            rd_q <= mem_q[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/lane_shaper.sv
module lane_shaper #(
    parameter int LANES = 16,
    parameter int CW    = 6,
    parameter int T0H   = 20,
    parameter int T1H   = 40
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic [CW-1:0]    phase_i,
    input  logic [LANES-1:0] en_i,
    input  logic [LANES-1:0] word_i,
    output logic [LANES-1:0] lanes_o
);
    logic [LANES-1:0] lanes_d, lanes_q;

    always_comb begin
        lanes_d = lanes_q;
        if (!active_i) begin
            lanes_d = '0;
        end else if (phase_i == '0) begin
            lanes_d = en_i;
        end else if (phase_i == CW'(T0H)) begin
            lanes_d = lanes_q & word_i;
        end else if (phase_i == CW'(T1H)) begin
            lanes_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lanes_q <= '0;
        end else begin
            lanes_q <= lanes_d;
        end
    end

    assign lanes_o = lanes_q;
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int GUARD_CYC = 2400,
    localparam int GW       = $clog2(GUARD_CYC + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = GW'(GUARD_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - GW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/parallel_strip_tx.sv
module parallel_strip_tx
    import parallel_strip_tx_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int MAX_LEDS = 60,
    parameter int CLK_MHZ  = 48,
    parameter int SLOT_NS  = 1250,
    parameter int GUARD_US = 50,
    localparam int SLOT_CYC  = SLOT_NS * CLK_MHZ / 1000,
    localparam int T0H       = SLOT_CYC / 3,
    localparam int T1H       = SLOT_CYC * 2 / 3,
    localparam int GUARD_CYC = GUARD_US * CLK_MHZ,
    localparam int MAX_WORDS = MAX_LEDS * BITS_PER_LED,
    localparam int AW        = $clog2(MAX_WORDS),
    localparam int LCW       = $clog2(MAX_LEDS + 1),
    localparam int WCW       = $clog2(MAX_WORDS + 1),
    localparam int SW        = $clog2(MAX_WORDS + 4),
    localparam int CW        = $clog2(SLOT_CYC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [LCW-1:0]   led_count_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [LANES-1:0] wr_data_i,
    output logic [LANES-1:0] lanes_o,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        tx_state_e        st;
        logic [CW-1:0]    cyc;
        logic [SW-1:0]    slot;
        logic [AW-1:0]    addr;
        logic [WCW-1:0]   words;
        logic [LANES-1:0] en;
        logic             pend;
        logic             done;
    } ctrl_t;

    ctrl_t            ctrl_d, ctrl_q;
    logic             rd_en;
    logic             load_guard;
    logic             guard_ok;
    logic             data_slot;
    logic [SW-1:0]    last_slot;
    logic [LCW-1:0]   led_n;
    logic [LANES-1:0] plane_word;

    // Names seen by the bound checker
    logic [CW-1:0]    phase_q;
    logic [SW-1:0]    slot_q;
    logic [LANES-1:0] en_q;
    assign phase_q = ctrl_q.cyc;
    assign slot_q  = ctrl_q.slot;
    assign en_q    = ctrl_q.en;

    assign last_slot = SW'(ctrl_q.words) + SW'(LEAD_SLOTS);
    assign data_slot = (ctrl_q.slot >= SW'(LEAD_SLOTS)) && (ctrl_q.slot < last_slot);
    assign led_n     = (led_count_i > LCW'(MAX_LEDS)) ? LCW'(MAX_LEDS) : led_count_i;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        rd_en       = 1'b0;
        load_guard  = 1'b0;
        if (start_i) begin
            ctrl_d.pend = 1'b1;
        end
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (start_i || ctrl_q.pend) begin
                    ctrl_d.st    = ST_SEND;
                    ctrl_d.cyc   = '0;
                    ctrl_d.slot  = '0;
                    ctrl_d.addr  = '0;
                    ctrl_d.words = WCW'(led_n) * WCW'(BITS_PER_LED);
                    ctrl_d.en    = lane_en_i;
                    ctrl_d.pend  = 1'b0;
                end
            end
            ST_SEND: begin
                // fetch at slot start; word is ready long before the one-third point
                if (data_slot && ctrl_q.cyc == '0) begin
                    rd_en       = 1'b1;
                    ctrl_d.addr = ctrl_q.addr + AW'(1);
                end
                if (ctrl_q.cyc == CW'(SLOT_CYC - 1)) begin
                    ctrl_d.cyc = '0;
                    if (ctrl_q.slot == last_slot) begin
                        ctrl_d.st   = ST_GUARD;
                        ctrl_d.done = 1'b1;
                        load_guard  = 1'b1;
                    end else begin
                        ctrl_d.slot = ctrl_q.slot + SW'(1);
                    end
                end else begin
                    ctrl_d.cyc = ctrl_q.cyc + CW'(1);
                end
            end
            ST_GUARD: begin
                if (guard_ok) begin
                    ctrl_d.st = ST_IDLE;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    lane_plane_ram #(
        .WIDTH (LANES),
        .DEPTH (MAX_WORDS)
    ) i_ram (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en),
        .rd_addr_i (ctrl_q.addr),
        .rd_data_o (plane_word)
    );

    lane_shaper #(
        .LANES (LANES),
        .CW    (CW),
        .T0H   (T0H),
        .T1H   (T1H)
    ) i_shaper (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i ((ctrl_q.st == ST_SEND) && data_slot),
        .phase_i  (ctrl_q.cyc),
        .en_i     (ctrl_q.en),
        .word_i   (plane_word),
        .lanes_o  (lanes_o)
    );

    guard_timer #(
        .GUARD_CYC (GUARD_CYC)
    ) i_guard (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_guard),
        .expired_o (guard_ok)
    );

    assign busy_o = (ctrl_q.st == ST_SEND);
    assign done_o = ctrl_q.done;
endmodule

// File: rtl/parallel_strip_tx_chk.sv
module parallel_strip_tx_chk #(
    parameter int LANES = 16,
    parameter int CW    = 6,
    parameter int SW    = 11,
    parameter int T0H   = 20,
    parameter int T1H   = 40
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [LANES-1:0] lanes_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [LANES-1:0] en_q,
    input logic [CW-1:0]    phase_q,
    input logic [SW-1:0]    slot_q
);
    p_quiet_outside_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (lanes_o == '0));

    p_rise_on_slot_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((lanes_o & ~$past(lanes_o)) != '0) |-> ($past(phase_q) == '0));

    p_fall_on_thirds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~lanes_o & $past(lanes_o)) != '0)
            |-> ($past(phase_q) == CW'(T0H) || $past(phase_q) == CW'(T1H)));

    p_masked_lanes_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lanes_o & ~en_q) == '0);

    p_no_rise_in_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((lanes_o & ~$past(lanes_o)) != '0) |-> ($past(slot_q) >= SW'(2)));

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind parallel_strip_tx parallel_strip_tx_chk #(
    .LANES (LANES),
    .CW    (CW),
    .SW    (SW),
    .T0H   (T0H),
    .T1H   (T1H)
) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lanes_o (lanes_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .en_q    (en_q),
    .phase_q (phase_q),
    .slot_q  (slot_q)
);

// File: tb/test_parallel_strip_tx.sv
module test_parallel_strip_tx;
    localparam int CLK_PERIOD = 20;
    localparam int LANES = 16;
    localparam int SLOT  = 60;
    localparam int T0H   = 20;
    localparam int T1H   = 40;
    localparam int GUARD = 2400;
    localparam int BMAX  = 256;
    localparam int LIMIT = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [5:0]        led_count_i = '0;
    logic [LANES-1:0]  lane_en_i = '0;
    logic              wr_en_i = 1'b0;
    logic [10:0]       wr_addr_i = '0;
    logic [LANES-1:0]  wr_data_i = '0;
    logic [LANES-1:0]  lanes_o;
    logic              busy_o;
    logic              done_o;

    parallel_strip_tx i_parallel_strip_tx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start_i),
        .led_count_i (led_count_i),
        .lane_en_i   (lane_en_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .lanes_o     (lanes_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int fails = 0;
    int now = 0;
    bit finished = 1'b0;

    always @(posedge clk) now <= now + 1;

    // ---------------- waveform monitor ----------------
    logic [LANES-1:0] prev_lanes = '0;
    logic             prev_busy = 1'b0;
    int rise_t [LANES];
    int last_rise [LANES];
    int rises [LANES];
    int nb [LANES];
    logic [BMAX-1:0] dec [LANES];
    int bad_width = 0;
    int bad_period = 0;
    int first_rise = -1;
    int last_fall = -1;
    int busy_rise = -1;
    int done_t = -1;
    int done_hi = 0;
    int done_cnt = 0;

    task automatic clear_mon();
        for (int l = 0; l < LANES; l++) begin
            rise_t[l] = 0; last_rise[l] = -1; rises[l] = 0; nb[l] = 0; dec[l] = '0;
        end
        bad_width = 0; bad_period = 0; first_rise = -1; last_fall = -1; done_hi = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !prev_busy) busy_rise = now;
            if (done_o) begin
                done_hi++;
                done_cnt++;
                done_t = now;
            end
            for (int l = 0; l < LANES; l++) begin
                if (lanes_o[l] && !prev_lanes[l]) begin
                    rises[l]++;
                    if (first_rise < 0) first_rise = now;
                    if (last_rise[l] >= 0 && now - last_rise[l] != SLOT) bad_period++;
                    last_rise[l] = now;
                    rise_t[l] = now;
                end
                if (!lanes_o[l] && prev_lanes[l]) begin
                    last_fall = now;
                    if (now - rise_t[l] != T1H && now - rise_t[l] != T0H) bad_width++;
                    if (nb[l] < BMAX) dec[l][nb[l]] = (now - rise_t[l] == T1H);
                    nb[l]++;
                end
            end
        end
        prev_lanes = lanes_o;
        prev_busy  = busy_o;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] colour(input int seed, input int l, input int p);
        logic [7:0] g, r, b;
        g = 8'(l * 17 + p * 29 + seed * 3);
        r = 8'((l * 5) ^ (p * 71 + seed));
        b = 8'(~(l * 13 + p + seed * 7));
        return {g, r, b};
    endfunction

    task automatic load(input int seed, input int leds);
        for (int w = 0; w < leds * 24; w++) begin
            logic [LANES-1:0] word;
            for (int l = 0; l < LANES; l++) begin
                logic [23:0] c;
                c = colour(seed, l, w / 24);
                word[l] = c[23 - (w % 24)];
            end
            @(negedge clk);
            wr_en_i = 1'b1; wr_addr_i = 11'(w); wr_data_i = word;
        end
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_start(input int leds, input logic [LANES-1:0] en);
        @(negedge clk);
        start_i = 1'b1; led_count_i = 6'(leds); lane_en_i = en;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic check_frame(input int seed, input int leds, input logic [LANES-1:0] en);
        for (int l = 0; l < LANES; l++) begin
            if (en[l]) begin
                int bad = 0;
                for (int w = 0; w < leds * 24; w++) begin
                    logic [23:0] c;
                    c = colour(seed, l, w / 24);
                    if (dec[l][w] !== c[23 - (w % 24)]) bad++;
                end
                check(nb[l] == leds * 24, "R4 bit count", nb[l], leds * 24);
                check(bad == 0, "R4 lane data", bad, 0);
            end else begin
                check(rises[l] == 0, "R5 disabled lane pulses", rises[l], 0);
            end
        end
        check(bad_period == 0, "R2 slot period", bad_period, 0);
        check(bad_width == 0, "R3 pulse widths", bad_width, 0);
        check(first_rise - busy_rise == 2 * SLOT + 1, "R6 lead slots",
              first_rise - busy_rise, 2 * SLOT + 1);
        check(done_t - last_fall == 2 * SLOT - T1H - 1, "R7 trailing slot",
              done_t - last_fall, 2 * SLOT - T1H - 1);
        check(done_hi == 1, "R7 done width", done_hi, 1);
        check(busy_o == 1'b0, "R7 busy after done", busy_o, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(lanes_o == '0, "R1 lanes at reset", lanes_o, 0);
        check(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
        check(done_o == 1'b0, "R1 done at reset", done_o, 0);
    endtask

    task automatic t_full_frame();
        load(1, 4);
        clear_mon();
        pulse_start(4, '1);
        wait_done(done_cnt + 1);
        check_frame(1, 4, '1);
        repeat (GUARD + 10) @(negedge clk);
        check(lanes_o == '0, "R1 lanes idle", lanes_o, 0);
    endtask

    task automatic t_masked_frame();
        load(2, 3);
        clear_mon();
        pulse_start(3, 16'hA5C3);
        wait_done(done_cnt + 1);
        check_frame(2, 3, 16'hA5C3);
        repeat (GUARD + 10) @(negedge clk);
    endtask

    task automatic t_pending();
        int d1, n0;
        n0 = done_cnt;
        load(3, 2);
        clear_mon();
        pulse_start(2, '1);
        repeat (500) @(negedge clk);
        check(busy_o == 1'b1, "R9 busy mid frame", busy_o, 1);
        pulse_start(1, '1);
        wait_done(n0 + 1);
        d1 = done_t;
        wait_done(n0 + 2);
        check(done_cnt == n0 + 2, "R9 pending frame ran", done_cnt - n0, 2);
        check(busy_rise - d1 >= GUARD, "R8 guard after pending", busy_rise - d1, GUARD);
        repeat (GUARD + 10) @(negedge clk);
    endtask

    task automatic t_guard_start();
        int d1, n0;
        n0 = done_cnt;
        clear_mon();
        pulse_start(1, '1);
        wait_done(n0 + 1);
        d1 = done_t;
        repeat (100) @(negedge clk);
        pulse_start(1, '1);
        repeat (50) @(negedge clk);
        check(busy_o == 1'b0, "R8 no restart inside guard", busy_o, 0);
        wait_done(n0 + 2);
        check(busy_rise - d1 >= GUARD, "R8 guard gap", busy_rise - d1, GUARD);
        repeat (GUARD + 10) @(negedge clk);
    endtask

    task automatic t_empty_frame();
        int pulses;
        clear_mon();
        pulse_start(0, '1);
        wait_done(done_cnt + 1);
        pulses = 0;
        for (int l = 0; l < LANES; l++) pulses += rises[l];
        check(pulses == 0, "R10 empty frame pulses", pulses, 0);
        check(done_t - busy_rise == 3 * SLOT, "R10 empty frame length",
              done_t - busy_rise, 3 * SLOT);
        repeat (GUARD + 10) @(negedge clk);
    endtask

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_frame();
        t_masked_frame();
        t_pending();
        t_guard_start();
        t_empty_frame();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        while (now < LIMIT) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", now, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule